// File: doc/BRIEF.md
# Priority Interrupt Request Unit

This block decides, at each instruction fetch boundary, whether the processor should leave the running program and enter a device service routine. Each device supplies a ready flag, an interrupt-enable flag and a 3-bit priority level. A device raises a request only when both of its flags are set. Among the requesting devices the block picks the one with the highest level, and it breaks ties toward the lower device index. It grants the interrupt only when that level is strictly above the level of the running program.

A grant produces a one-cycle `take_irq` pulse, which tells the CPU control to save PC and PSR and branch. The block also drives an 8-bit vector number for the winning device. The running level rises to the granted level, and the level that was replaced goes onto an internal last-in-first-out store. A return-from-interrupt strobe takes the most recent saved level back off that store, so nested service routines unwind in order. The block does not model stack memory traffic or the datapath.

Top module: `pir_unit`

## Requirements
- R1: A device requests only when its `dev_ready` bit and its `dev_ien` bit are both 1. A device with only one of the two bits set is never granted.
- R2: Among the requesting devices the highest level wins, and equal levels go to the lower device index. `irq_vector` = `VEC_BASE` (default 0x20) + the winner's index, so with the defaults device 0 is 0x20 and device 3 is 0x23.
- R3: A grant is evaluated only at a clock edge where `fetch_bound` is 1. With `fetch_bound` at 0 a qualifying request causes no grant and no change of `run_level`.
- R4: A grant requires the winner's level to be strictly greater than `run_level`. When the winner's level is equal or lower, there is no pulse and `run_level` is unchanged.
- R5: After the edge that grants, `take_irq` is 1 for exactly that one cycle, and in the same cycle `irq_vector` shows the winner's vector and `run_level` equals the granted level.
- R6: An `irq_return` strobe at a clock edge restores the level that was in force before the most recent grant that is still outstanding. Nested grants unwind in last-in-first-out order.
- R7: `irq_return` with no outstanding grant is ignored, and `run_level` stays as it is. `irq_return` also takes precedence over `fetch_bound` in the same cycle, so no grant happens in that cycle.
- R8: After reset `take_irq` is 0, `run_level` is 0 and `irq_vector` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_ready | input | NUM_DEV | Per-device ready flag |
| dev_ien | input | NUM_DEV | Per-device interrupt-enable flag |
| dev_level | input | NUM_DEV*PRIO_W | Per-device priority level, device i in bits [i*PRIO_W +: PRIO_W] |
| fetch_bound | input | 1 | High in the cycle before an instruction fetch |
| irq_return | input | 1 | Return-from-interrupt strobe |
| take_irq | output | 1 | One-cycle grant pulse: save PC and PSR, then branch |
| irq_vector | output | VEC_W | Vector number of the last granted device |
| run_level | output | PRIO_W | Priority level of the running program |

## Verification
Every result is registered, so it is due in the cycle right after the edge at which `fetch_bound` or `irq_return` was sampled. The bench drives its inputs on the falling edge and holds each strobe for exactly one rising edge. It then reads `take_irq`, `irq_vector` and `run_level` one time unit after that rising edge. It reads `take_irq` again one cycle later to confirm that the pulse has ended. For the negative cases (a missing flag, an equal or lower level, no fetch boundary, a return with nothing outstanding) it samples at the same point, to show that nothing moved.

// File: rtl/pir_pkg.sv
package pir_pkg;
   typedef enum logic [1:0] {
      ACT_IDLE   = 2'd0,
      ACT_GRANT  = 2'd1,
      ACT_RETURN = 2'd2
   } pir_act_e;
endpackage

// File: rtl/pir_arbiter.sv
module pir_arbiter #(
   parameter int NUM_DEV = 4,
   parameter int PRIO_W  = 3,
   localparam int IDX_W  = $clog2(NUM_DEV)
) (
   input  logic [NUM_DEV-1:0]        req,
   input  logic [NUM_DEV*PRIO_W-1:0] lvl_flat,
   output logic                      win_any,
   output logic [IDX_W-1:0]          win_idx,
   output logic [PRIO_W-1:0]         win_lvl
);
   logic [PRIO_W-1:0] lvl [NUM_DEV];

   for (genvar g = 0; g < NUM_DEV; g++) begin : g_unpack
      assign lvl[g] = lvl_flat[g*PRIO_W +: PRIO_W];
   end

   // scan upward; strictly-greater keeps the lower index on ties
   always_comb begin
      win_any = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = 0; i < NUM_DEV; i++) begin
         if (req[i] && (!win_any || lvl[i] > win_lvl)) begin
            win_any = 1'b1;
            win_idx = IDX_W'(i);
            win_lvl = lvl[i];
         end
      end
   end

   // R2: the reported winner is itself requesting and nothing beats it
   always_comb begin
      if (win_any) begin
         a_r2_winner_requests : assert (req[win_idx]);
      end else begin
         a_r2_idle_no_req : assert (req == '0);
      end
   end
endmodule

// File: rtl/pir_level_stack.sv
module pir_level_stack #(
   parameter int PRIO_W = 3,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [PRIO_W-1:0] din,
   output logic [PRIO_W-1:0] top,
   output logic              empty
);
   logic [PRIO_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0]  cnt;
   logic              full;

   assign empty = (cnt == '0);
   assign full  = (cnt == CNT_W'(DEPTH));
   assign top   = mem[IDX_W'(cnt - 1'b1)];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push) begin
         mem[IDX_W'(cnt)] <= din;
         cnt <= cnt + 1'b1;
      end else if (pop) begin
         cnt <= cnt - 1'b1;
      end
   end

   // R6: levels only ever rise on push, so depth never exceeds the level count
   a_r6_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R7: the control never pops an empty store
   a_r7_pop_guarded : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/pir_unit.sv
module pir_unit #(
   parameter int NUM_DEV  = 4,
   parameter int PRIO_W   = 3,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 32,
   localparam int IDX_W   = $clog2(NUM_DEV),
   localparam int DEPTH   = 1 << PRIO_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_DEV-1:0]        dev_ready,
   input  logic [NUM_DEV-1:0]        dev_ien,
   input  logic [NUM_DEV*PRIO_W-1:0] dev_level,
   input  logic                      fetch_bound,
   input  logic                      irq_return,
   output logic                      take_irq,
   output logic [VEC_W-1:0]          irq_vector,
   output logic [PRIO_W-1:0]         run_level
);
   import pir_pkg::*;

   if (NUM_DEV < 2) begin : g_bad_ndev
      $error("pir_unit: NUM_DEV must be at least 2");
   end
   if (PRIO_W < 1 || PRIO_W > 6) begin : g_bad_prio
      $error("pir_unit: PRIO_W out of range");
   end
   if (VEC_BASE + NUM_DEV > (1 << VEC_W)) begin : g_bad_vec
      $error("pir_unit: vectors do not fit in VEC_W bits");
   end

   logic [NUM_DEV-1:0] req;
   logic               win_any;
   logic [IDX_W-1:0]   win_idx;
   logic [PRIO_W-1:0]  win_lvl;
   logic [PRIO_W-1:0]  saved_lvl;
   logic               stk_empty;
   pir_act_e           act;

   assign req = dev_ready & dev_ien;

   pir_arbiter #(.NUM_DEV(NUM_DEV), .PRIO_W(PRIO_W)) u_arb (
      .req      (req),
      .lvl_flat (dev_level),
      .win_any  (win_any),
      .win_idx  (win_idx),
      .win_lvl  (win_lvl)
   );

   pir_level_stack #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_stk (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (act == ACT_GRANT),
      .pop   (act == ACT_RETURN),
      .din   (run_level),
      .top   (saved_lvl),
      .empty (stk_empty)
   );

   always_comb begin
      act = ACT_IDLE;
      if (irq_return) begin
         if (!stk_empty) act = ACT_RETURN;
      end else if (fetch_bound && win_any && (win_lvl > run_level)) begin
         act = ACT_GRANT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_irq   <= 1'b0;
         irq_vector <= '0;
         run_level  <= '0;
      end else begin
         take_irq <= (act == ACT_GRANT);
         if (act == ACT_GRANT) begin
            run_level  <= win_lvl;
            irq_vector <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
         end else if (act == ACT_RETURN) begin
            run_level <= saved_lvl;
         end
      end
   end

   // R3: a grant pulse follows a sampled fetch boundary
   a_r3_only_at_fetch : assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> $past(fetch_bound) && !$past(irq_return));
   // R4: every grant strictly raises the running level
   a_r4_strict_raise : assert property (@(posedge clk) disable iff (!rst_n)
      take_irq |-> run_level > $past(run_level));
   // R6: an honoured return lowers the level
   a_r6_return_lowers : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_return && !stk_empty) |=> run_level < $past(run_level));
   // R7: a return with nothing outstanding leaves the level alone and grants nothing
   a_r7_empty_return : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_return && stk_empty) |=> $stable(run_level) && !take_irq);
endmodule

// File: tb/pir_unit_test.sv
module pir_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int ND = 4;
   localparam int PW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [ND-1:0] dev_ready = '0;
   logic [ND-1:0] dev_ien = '0;
   logic [ND*PW-1:0] dev_level = '0;
   logic          fetch_bound = 1'b0;
   logic          irq_return = 1'b0;
   logic          take_irq;
   logic [7:0]    irq_vector;
   logic [PW-1:0] run_level;

   int total = 0;
   int bad = 0;

   pir_unit #(.NUM_DEV(ND), .PRIO_W(PW), .VEC_W(8), .VEC_BASE(32)) uut (
      .clk(clk), .rst_n(rst_n), .dev_ready(dev_ready), .dev_ien(dev_ien),
      .dev_level(dev_level), .fetch_bound(fetch_bound), .irq_return(irq_return),
      .take_irq(take_irq), .irq_vector(irq_vector), .run_level(run_level));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_dev(input int i, input logic r, input logic e, input int lv);
      dev_ready[i] = r;
      dev_ien[i]   = e;
      dev_level[i*PW +: PW] = PW'(lv);
   endtask

   task automatic clear_devs();
      @(negedge clk);
      dev_ready = '0; dev_ien = '0; dev_level = '0;
   endtask

   // one fetch boundary; outputs sampled just after the edge
   task automatic fetch_once();
      @(negedge clk); fetch_bound = 1'b1;
      @(posedge clk); #1;
      @(negedge clk); fetch_bound = 1'b0;
   endtask

   task automatic ret_once();
      @(negedge clk); irq_return = 1'b1;
      @(posedge clk); #1;
      @(negedge clk); irq_return = 1'b0;
   endtask

   // fetch and check result in the cycle after the edge
   task automatic fetch_expect(input string tag, input int tk, input int vec, input int lv);
      @(negedge clk); fetch_bound = 1'b1;
      @(posedge clk); #1;
      chk({tag, " take"}, int'(take_irq), tk);
      if (tk != 0) chk({tag, " vector"}, int'(irq_vector), vec);
      chk({tag, " level"}, int'(run_level), lv);
      @(negedge clk); fetch_bound = 1'b0;
   endtask

   task automatic ret_expect(input string tag, input int lv);
      ret_once();
      chk({tag, " level"}, int'(run_level), lv);
      chk({tag, " no take"}, int'(take_irq), 0);
   endtask

   task automatic t_reset();
      chk("R8 take after reset", int'(take_irq), 0);
      chk("R8 level after reset", int'(run_level), 0);
      chk("R8 vector after reset", int'(irq_vector), 0);
   endtask

   task automatic t_qualify();
      clear_devs();
      set_dev(0, 1'b1, 1'b0, 5);
      fetch_expect("R1 ready only", 0, 0, 0);
      @(negedge clk); set_dev(0, 1'b0, 1'b1, 5);
      fetch_expect("R1 enable only", 0, 0, 0);
      @(negedge clk); set_dev(0, 1'b1, 1'b1, 5);
      fetch_expect("R1 both set", 1, 8'h20, 5);
      @(posedge clk); #1;
      chk("R5 pulse ends", int'(take_irq), 0);
      clear_devs();
      ret_expect("R6 back to 0", 0);
   endtask

   task automatic t_fetch_gate();
      clear_devs();
      set_dev(1, 1'b1, 1'b1, 3);
      repeat (3) @(posedge clk);
      #1;
      chk("R3 no fetch take", int'(take_irq), 0);
      chk("R3 no fetch level", int'(run_level), 0);
      fetch_expect("R3 fetch grants", 1, 8'h21, 3);
      clear_devs();
      ret_expect("R6 after R3", 0);
   endtask

   task automatic t_pick();
      clear_devs();
      set_dev(1, 1'b1, 1'b1, 4);
      set_dev(2, 1'b1, 1'b1, 6);
      set_dev(3, 1'b1, 1'b1, 6);
      fetch_expect("R2 highest and tie low index", 1, 8'h22, 6);
      clear_devs();
      ret_expect("R6 after R2", 0);
   endtask

   task automatic t_strict();
      clear_devs();
      set_dev(0, 1'b1, 1'b1, 4);
      fetch_expect("R4 first raise", 1, 8'h20, 4);
      clear_devs();
      set_dev(1, 1'b1, 1'b1, 4);
      fetch_expect("R4 equal level", 0, 0, 4);
      @(negedge clk); set_dev(1, 1'b1, 1'b1, 2);
      fetch_expect("R4 lower level", 0, 0, 4);
      @(negedge clk); set_dev(1, 1'b1, 1'b1, 5);
      fetch_expect("R4 higher level", 1, 8'h21, 5);
      clear_devs();
      ret_expect("R6 unwind to 4", 4);
      ret_expect("R6 unwind to 0", 0);
   endtask

   task automatic t_nest();
      clear_devs();
      set_dev(0, 1'b1, 1'b1, 1);
      fetch_expect("R6 nest level 1", 1, 8'h20, 1);
      @(negedge clk); set_dev(1, 1'b1, 1'b1, 3);
      fetch_expect("R6 nest level 3", 1, 8'h21, 3);
      @(negedge clk); set_dev(2, 1'b1, 1'b1, 7);
      fetch_expect("R6 nest level 7", 1, 8'h22, 7);
      clear_devs();
      ret_expect("R6 pop to 3", 3);
      ret_expect("R6 pop to 1", 1);
      ret_expect("R6 pop to 0", 0);
      ret_expect("R7 extra return ignored", 0);
   endtask

   task automatic t_precedence();
      clear_devs();
      set_dev(3, 1'b1, 1'b1, 2);
      @(negedge clk); fetch_bound = 1'b1; irq_return = 1'b1;
      @(posedge clk); #1;
      chk("R7 return beats fetch take", int'(take_irq), 0);
      chk("R7 return beats fetch level", int'(run_level), 0);
      @(negedge clk); fetch_bound = 1'b0; irq_return = 1'b0;
      fetch_expect("R7 later fetch grants", 1, 8'h23, 2);
      clear_devs();
      ret_expect("R6 after R7", 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_qualify();
      t_fetch_gate();
      t_pick();
      t_strict();
      t_nest();
      t_precedence();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule